// File: doc/BRIEF.md
# Counter Clock and Gate Source Selector

This block chooses, for each of six counter channels, which signal clocks the channel and which signal gates it. The six channels sit in two chips of three channels each. Every channel holds two 5-bit source codes, one for the clock and one for the gate. A single select byte, written through either the clock-select strobe or the gate-select strobe, names the chip, the channel and the new code. From one system clock of nominally 40 MHz the block also derives single-cycle timebase pulses at 20 MHz, 10 MHz, 1 MHz, 10 kHz and 1 kHz.

For each channel the block drives a one-cycle clock enable and a gate level. Sources taken from pins or from counter outputs pass through a two-flop synchronizer. A rising edge of the synchronized value becomes a one-cycle clock enable. The synchronized level itself is used as a gate. An enhanced-mode input widens the range of accepted codes to include constant levels, a pattern-present signal and the 20 MHz timebase.

Top module: `ctr_src_select`

## Requirements
- R1: After reset every channel selects code 0 for both clock and gate. With all pins low, every clock enable and every gate level is 0.
- R2: The select byte is decoded as follows. Bit 5 is the chip. Bits 4:3 are the channel within the chip. The source code is {bits 7:6, bits 2:0}. Chip c, channel n addresses output index 3*c+n.
- R3: A write with channel field 3 changes no setting.
- R4: With the enhanced input low, codes 0 to 7 are accepted and codes 8 to 31 leave the setting unchanged.
- R5: With the enhanced input high, codes 0 to 10 are accepted and codes 11 to 31 leave the setting unchanged.
- R6: Timebase codes give one-cycle clock-enable pulses at these periods: code 10 every 2 cycles, code 1 every 4, code 2 every 40, code 3 every 4000 and code 4 every 40000.
- R7: Code 0 selects the channel's own clock pin or gate pin through a two-flop synchronizer. The clock enable is high for exactly the one cycle after the second rising clock edge that sees the pin high. The gate level follows the pin after two edges.
- R8: Code 5 selects the output of channel (i+5) mod 6. The first channel of each chip therefore takes the last channel of the other chip.
- R9: Code 6 selects the group clock pin of the channel's own chip, synchronized.
- R10: Code 7 gives a gate level of 1 and code 8 gives a gate level of 0. Both codes give a clock enable of 0.
- R11: Code 9 selects the pattern-present input. The gate follows it in the same cycle, and its rising edge gives a clock enable in the same cycle.
- R12: The clock and gate settings of a channel are separate. A write takes effect at the clock edge that samples the strobe and touches only the register of the strobe used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 40 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| enhanced | input | 1 | Widens the accepted source code range |
| clkSelWr | input | 1 | Write strobe for the clock-source setting |
| gateSelWr | input | 1 | Write strobe for the gate-source setting |
| wrData | input | 8 | Select byte |
| clkPin | input | 6 | Dedicated clock pin per channel (asynchronous) |
| gatePin | input | 6 | Dedicated gate pin per channel (asynchronous) |
| grpClkPin | input | 2 | Group clock pin per chip (asynchronous) |
| ctrOut | input | 6 | Counter channel outputs (asynchronous) |
| patPresent | input | 1 | Pattern-present signal, synchronous to clk |
| ctrClkEn | output | 6 | One-cycle clock enable per channel |
| ctrGateLvl | output | 6 | Gate level per channel |

## Verification
Random select bytes, with the enhanced input also random, are mixed with held random pin levels. Each setting is then judged by a 40-cycle window. The window counts clock enables and gate-high cycles: static sources give 0 or 40 gate cycles and no enables, while the timebase codes give 20, 10 or 1 pulses. This shows whether a write landed on the addressed channel and whether it was correctly rejected. Directed patterns cover the remaining cases. Single-bit counter outputs show the wrap of the neighbour chain across chips. Pin steps measure the synchronizer latency. A pattern step shows the same-cycle edge. Long waits measure the slow timebase periods.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;
  localparam int NUM_CHIPS     = 2;
  localparam int CHAN_PER_CHIP = 3;
  localparam int NUM_CHAN      = NUM_CHIPS * CHAN_PER_CHIP;
  localparam int SRC_W         = 5;
  localparam int SEL_W         = 8;
  localparam int NUM_TICKS     = 5;

  // select byte field positions (decoded by software-visible layout)
  localparam int CHIP_BIT   = 5;
  localparam int CHAN_LSB   = 3;
  localparam int SRC_LO_W   = 3;
  localparam int SRC_HI_LSB = 6;

  typedef logic [SRC_W-1:0] srcCode_t;

  localparam srcCode_t SRC_PIN     = 5'd0;
  localparam srcCode_t SRC_10M     = 5'd1;
  localparam srcCode_t SRC_1M      = 5'd2;
  localparam srcCode_t SRC_10K     = 5'd3;
  localparam srcCode_t SRC_1K      = 5'd4;
  localparam srcCode_t SRC_PREV    = 5'd5;
  localparam srcCode_t SRC_GRP     = 5'd6;
  localparam srcCode_t SRC_HIGH    = 5'd7;
  localparam srcCode_t SRC_LOW     = 5'd8;
  localparam srcCode_t SRC_PAT     = 5'd9;
  localparam srcCode_t SRC_20M     = 5'd10;
  localparam srcCode_t SRC_MAX_STD = 5'd7;
  localparam srcCode_t SRC_MAX_ENH = 5'd10;

  // timebase pulse indices, fastest first
  localparam int TB_20M = 0;
  localparam int TB_10M = 1;
  localparam int TB_1M  = 2;
  localparam int TB_10K = 3;
  localparam int TB_1K  = 4;

  typedef struct packed {
    logic [NUM_CHAN-1:0] clkLoad;
    logic [NUM_CHAN-1:0] gateLoad;
    srcCode_t            code;
  } selStrobe_t;
endpackage

// File: rtl/ctr_src_timebase.sv
module ctr_src_timebase
  import ctr_src_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int R10M     = 2,
  parameter int R1M      = 10,
  parameter int R10K     = 100,
  parameter int R1K      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [NUM_TICKS-1:0] tick
);
  localparam int RATIO [NUM_TICKS] = '{DIV_FAST, R10M, R1M, R10K, R1K};

  for (genvar s = 0; s < NUM_TICKS; s++) begin : g_stage
    localparam int CW = (RATIO[s] > 2) ? $clog2(RATIO[s]) : 1;
    logic [CW-1:0] cnt;
    logic          stepEn;
    logic          pulse;

    if (s == 0) begin : g_first
      assign stepEn = 1'b1;
    end else begin : g_next
      assign stepEn = g_stage[s-1].pulse;
    end

    assign pulse   = stepEn && (cnt == CW'(RATIO[s] - 1));
    assign tick[s] = pulse;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       cnt <= '0;
      else if (stepEn) cnt <= pulse ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctr_src_sync.sv
module ctr_src_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] async,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      lvl    <= '0;
    end else begin
      stage1 <= async;
      lvl    <= stage1;
    end
  end
endmodule

// File: rtl/ctr_src_ctrl.sv
module ctr_src_ctrl
  import ctr_src_pkg::*;
(
  input  logic             clkSelWr,
  input  logic             gateSelWr,
  input  logic             enhanced,
  input  logic [SEL_W-1:0] wrData,
  output selStrobe_t       strobe
);
  int       chipIdx;
  int       chanIdx;
  int       target;
  srcCode_t code;
  srcCode_t limit;
  logic     legal;

  always_comb begin
    chipIdx = int'(wrData[CHIP_BIT]);
    chanIdx = int'(wrData[CHAN_LSB +: 2]);
    code    = {wrData[SRC_HI_LSB +: SRC_W-SRC_LO_W], wrData[SRC_LO_W-1:0]};
    limit   = enhanced ? SRC_MAX_ENH : SRC_MAX_STD;
    legal   = (chanIdx < CHAN_PER_CHIP) && (code <= limit);
    target  = chipIdx * CHAN_PER_CHIP + chanIdx;
    strobe.code = code;
    for (int c = 0; c < NUM_CHAN; c++) begin
      strobe.clkLoad[c]  = clkSelWr  && legal && (target == c);
      strobe.gateLoad[c] = gateSelWr && legal && (target == c);
    end
  end
endmodule

// File: rtl/ctr_src_datapath.sv
module ctr_src_datapath
  import ctr_src_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  selStrobe_t                strobe,
  input  logic [NUM_TICKS-1:0]      tick,
  input  logic [NUM_CHAN-1:0]       clkPin,
  input  logic [NUM_CHAN-1:0]       gatePin,
  input  logic [NUM_CHIPS-1:0]      grpClkPin,
  input  logic [NUM_CHAN-1:0]       ctrOut,
  input  logic                      patPresent,
  output logic [NUM_CHAN-1:0]       ctrClkEn,
  output logic [NUM_CHAN-1:0]       ctrGateLvl,
  output logic [NUM_CHAN*SRC_W-1:0] clkSelFlat,
  output logic [NUM_CHAN*SRC_W-1:0] gateSelFlat
);
  localparam int SHARED_W = NUM_CHAN + NUM_CHIPS;

  logic [NUM_CHAN-1:0] clkLvl, clkLvlQ, clkRise;
  logic [NUM_CHAN-1:0] gateLvlS;
  logic [SHARED_W-1:0] sharedLvl, sharedLvlQ, sharedRise;
  logic                patQ, patRise;

  ctr_src_sync #(.W(NUM_CHAN)) u_syncClk (
    .clk(clk), .rstN(rstN), .async(clkPin), .lvl(clkLvl));
  ctr_src_sync #(.W(NUM_CHAN)) u_syncGate (
    .clk(clk), .rstN(rstN), .async(gatePin), .lvl(gateLvlS));
  ctr_src_sync #(.W(SHARED_W)) u_syncShared (
    .clk(clk), .rstN(rstN), .async({grpClkPin, ctrOut}), .lvl(sharedLvl));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkLvlQ    <= '0;
      sharedLvlQ <= '0;
      patQ       <= 1'b0;
    end else begin
      clkLvlQ    <= clkLvl;
      sharedLvlQ <= sharedLvl;
      patQ       <= patPresent;
    end
  end

  assign clkRise    = clkLvl & ~clkLvlQ;
  assign sharedRise = sharedLvl & ~sharedLvlQ;
  assign patRise    = patPresent & ~patQ;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam int PREV = (c + NUM_CHAN - 1) % NUM_CHAN;
    localparam int GRP  = NUM_CHAN + c / CHAN_PER_CHIP;
    srcCode_t clkSel, gateSel;
    logic     enSel, lvlSel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkSel  <= SRC_PIN;
        gateSel <= SRC_PIN;
      end else begin
        if (strobe.clkLoad[c])  clkSel  <= strobe.code;
        if (strobe.gateLoad[c]) gateSel <= strobe.code;
      end
    end

    always_comb begin
      case (clkSel)
        SRC_PIN:  enSel = clkRise[c];
        SRC_10M:  enSel = tick[TB_10M];
        SRC_1M:   enSel = tick[TB_1M];
        SRC_10K:  enSel = tick[TB_10K];
        SRC_1K:   enSel = tick[TB_1K];
        SRC_PREV: enSel = sharedRise[PREV];
        SRC_GRP:  enSel = sharedRise[GRP];
        SRC_PAT:  enSel = patRise;
        SRC_20M:  enSel = tick[TB_20M];
        default:  enSel = 1'b0;
      endcase
    end

    always_comb begin
      case (gateSel)
        SRC_PIN:  lvlSel = gateLvlS[c];
        SRC_10M:  lvlSel = tick[TB_10M];
        SRC_1M:   lvlSel = tick[TB_1M];
        SRC_10K:  lvlSel = tick[TB_10K];
        SRC_1K:   lvlSel = tick[TB_1K];
        SRC_PREV: lvlSel = sharedLvl[PREV];
        SRC_GRP:  lvlSel = sharedLvl[GRP];
        SRC_HIGH: lvlSel = 1'b1;
        SRC_PAT:  lvlSel = patPresent;
        SRC_20M:  lvlSel = tick[TB_20M];
        default:  lvlSel = 1'b0;
      endcase
    end

    assign ctrClkEn[c]                    = enSel;
    assign ctrGateLvl[c]                  = lvlSel;
    assign clkSelFlat[c*SRC_W +: SRC_W]  = clkSel;
    assign gateSelFlat[c*SRC_W +: SRC_W] = gateSel;
  end
endmodule

// File: rtl/ctr_src_select.sv
module ctr_src_select
  import ctr_src_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int R10M     = 2,
  parameter int R1M      = 10,
  parameter int R10K     = 100,
  parameter int R1K      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enhanced,
  input  logic                 clkSelWr,
  input  logic                 gateSelWr,
  input  logic [SEL_W-1:0]     wrData,
  input  logic [NUM_CHAN-1:0]  clkPin,
  input  logic [NUM_CHAN-1:0]  gatePin,
  input  logic [NUM_CHIPS-1:0] grpClkPin,
  input  logic [NUM_CHAN-1:0]  ctrOut,
  input  logic                 patPresent,
  output logic [NUM_CHAN-1:0]  ctrClkEn,
  output logic [NUM_CHAN-1:0]  ctrGateLvl
);
  selStrobe_t                selStrobe;
  logic [NUM_TICKS-1:0]      tickBus;
  logic [NUM_CHAN*SRC_W-1:0] clkSelFlat;
  logic [NUM_CHAN*SRC_W-1:0] gateSelFlat;

  ctr_src_ctrl u_ctrl (
    .clkSelWr (clkSelWr),
    .gateSelWr(gateSelWr),
    .enhanced (enhanced),
    .wrData   (wrData),
    .strobe   (selStrobe)
  );

  ctr_src_timebase #(
    .DIV_FAST(DIV_FAST), .R10M(R10M), .R1M(R1M), .R10K(R10K), .R1K(R1K)
  ) u_timebase (
    .clk (clk),
    .rstN(rstN),
    .tick(tickBus)
  );

  ctr_src_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (selStrobe),
    .tick       (tickBus),
    .clkPin     (clkPin),
    .gatePin    (gatePin),
    .grpClkPin  (grpClkPin),
    .ctrOut     (ctrOut),
    .patPresent (patPresent),
    .ctrClkEn   (ctrClkEn),
    .ctrGateLvl (ctrGateLvl),
    .clkSelFlat (clkSelFlat),
    .gateSelFlat(gateSelFlat)
  );
endmodule

// File: rtl/ctr_src_select_chk.sv
module ctr_src_select_chk
  import ctr_src_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      enhanced,
  input logic                      clkSelWr,
  input logic                      gateSelWr,
  input logic [SEL_W-1:0]          wrData,
  input logic [NUM_TICKS-1:0]      tickBus,
  input logic [NUM_CHAN*SRC_W-1:0] clkSelFlat,
  input logic [NUM_CHAN*SRC_W-1:0] gateSelFlat,
  input logic [NUM_CHAN-1:0]       ctrClkEn,
  input logic [NUM_CHAN-1:0]       ctrGateLvl
);
  logic     anyWr;
  srcCode_t wrCode;
  assign anyWr  = clkSelWr || gateSelWr;
  assign wrCode = {wrData[7:6], wrData[2:0]};

  // R3
  chan3_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && wrData[4:3] == 2'd3) |=> ($stable(clkSelFlat) && $stable(gateSelFlat)));

  // R4
  std_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && !enhanced && wrData[7:6] != 2'b00) |=> ($stable(clkSelFlat) && $stable(gateSelFlat)));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && enhanced && wrCode > 5'd10) |=> ($stable(clkSelFlat) && $stable(gateSelFlat)));

  for (genvar t = 0; t < NUM_TICKS; t++) begin : g_tick
    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickBus[t] |=> !tickBus[t]);
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    // R10
    gate_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (gateSelFlat[c*SRC_W +: SRC_W] == SRC_HIGH) |-> ctrGateLvl[c]);
    // R10
    gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (gateSelFlat[c*SRC_W +: SRC_W] == SRC_LOW) |-> !ctrGateLvl[c]);
    // R10
    const_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clkSelFlat[c*SRC_W +: SRC_W] == SRC_HIGH || clkSelFlat[c*SRC_W +: SRC_W] == SRC_LOW)
        |-> !ctrClkEn[c]);
  end
endmodule

bind ctr_src_select ctr_src_select_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enhanced   (enhanced),
  .clkSelWr   (clkSelWr),
  .gateSelWr  (gateSelWr),
  .wrData     (wrData),
  .tickBus    (tickBus),
  .clkSelFlat (clkSelFlat),
  .gateSelFlat(gateSelFlat),
  .ctrClkEn   (ctrClkEn),
  .ctrGateLvl (ctrGateLvl)
);

// File: tb/test_ctr_src_select.sv
`timescale 1ns/1ps
module test_ctr_src_select;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enhanced = 1'b0;
  logic       clkSelWr = 1'b0;
  logic       gateSelWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [5:0] clkPin = '0;
  logic [5:0] gatePin = '0;
  logic [1:0] grpClkPin = '0;
  logic [5:0] ctrOut = '0;
  logic       patPresent = 1'b0;
  logic [5:0] ctrClkEn;
  logic [5:0] ctrGateLvl;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int mClk [6];
  int mGate[6];

  always #5 clk = ~clk;

  ctr_src_select i_ctr_src_select (
    .clk(clk), .rstN(rstN), .enhanced(enhanced), .clkSelWr(clkSelWr),
    .gateSelWr(gateSelWr), .wrData(wrData), .clkPin(clkPin), .gatePin(gatePin),
    .grpClkPin(grpClkPin), .ctrOut(ctrOut), .patPresent(patPresent),
    .ctrClkEn(ctrClkEn), .ctrGateLvl(ctrGateLvl));

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(int chip, int chan, int code);
    logic [4:0] c5;
    logic [1:0] ch2;
    c5  = code[4:0];
    ch2 = chan[1:0];
    return {c5[4:3], chip[0], ch2, c5[2:0]};
  endfunction

  task automatic writeSel(bit toClk, bit toGate, logic [7:0] b);
    int chan, code, lim;
    @(negedge clk);
    clkSelWr = toClk; gateSelWr = toGate; wrData = b;
    @(negedge clk);
    clkSelWr = 1'b0; gateSelWr = 1'b0;
    chan = int'(b[4:3]);
    code = int'({b[7:6], b[2:0]});
    lim  = enhanced ? 10 : 7;
    if (chan < 3 && code <= lim) begin
      if (toClk)  mClk [int'(b[5]) * 3 + chan] = code;
      if (toGate) mGate[int'(b[5]) * 3 + chan] = code;
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // expected level of a static (non-timebase) gate source
  function automatic int staticGate(int code, int ch);
    case (code)
      0: return int'(gatePin[ch]);
      5: return int'(ctrOut[(ch + 5) % 6]);
      6: return int'(grpClkPin[ch / 3]);
      7: return 1;
      9: return int'(patPresent);
      default: return 0;
    endcase
  endfunction

  // pulses in a 40-cycle window for a timebase code, -1 if not exact, -2 if static
  function automatic int tickCount(int code);
    case (code)
      10: return 20;
      1:  return 10;
      2:  return 1;
      3, 4: return -1;
      default: return -2;
    endcase
  endfunction

  task automatic measure(int ch, output int n);
    do @(negedge clk); while (!ctrClkEn[ch]);
    n = 0;
    do begin @(negedge clk); n++; end while (!ctrClkEn[ch]);
  endtask

  task automatic windowCheck(string req);
    int cClk[6], cGate[6];
    for (int c = 0; c < 6; c++) begin cClk[c] = 0; cGate[c] = 0; end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      for (int c = 0; c < 6; c++) begin
        cClk[c]  += int'(ctrClkEn[c]);
        cGate[c] += int'(ctrGateLvl[c]);
      end
    end
    for (int c = 0; c < 6; c++) begin
      int tg, tc;
      tg = tickCount(mGate[c]);
      tc = tickCount(mClk[c]);
      if (tg == -2) check(cGate[c] == 40 * staticGate(mGate[c], c), req, "gate window", cGate[c], 40 * staticGate(mGate[c], c));
      else if (tg == -1) check(cGate[c] <= 1, req, "slow gate window", cGate[c], 1);
      else check(cGate[c] == tg, req, "tick gate window", cGate[c], tg);
      if (tc == -2) check(cClk[c] == 0, req, "static clk window", cClk[c], 0);
      else if (tc == -1) check(cClk[c] <= 1, req, "slow clk window", cClk[c], 1);
      else check(cClk[c] == tc, req, "tick clk window", cClk[c], tc);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] b;
    void'($urandom(32'h1234abcd));
    for (int c = 0; c < 6; c++) begin mClk[c] = 0; mGate[c] = 0; end
    repeat (3) @(negedge clk);
    check(ctrClkEn == 6'd0 && ctrGateLvl == 6'd0, "R1", "outputs in reset", int'({ctrClkEn, ctrGateLvl}), 0);
    rstN = 1'b1;
    settle();
    check(ctrClkEn == 6'd0 && ctrGateLvl == 6'd0, "R1", "outputs after reset", int'({ctrClkEn, ctrGateLvl}), 0);

    // R7 synchronizer latency on default source 0
    @(negedge clk); clkPin[0] = 1'b1; gatePin[1] = 1'b1;
    @(negedge clk);
    check(ctrClkEn[0] == 1'b0, "R7", "clkEn after one edge", int'(ctrClkEn[0]), 0);
    check(ctrGateLvl[1] == 1'b0, "R7", "gate after one edge", int'(ctrGateLvl[1]), 0);
    @(negedge clk);
    check(ctrClkEn == 6'b000001, "R7", "clkEn after two edges", int'(ctrClkEn), 1);
    check(ctrGateLvl == 6'b000010, "R1", "gate follows own pin", int'(ctrGateLvl), 2);
    @(negedge clk);
    check(ctrClkEn[0] == 1'b0, "R7", "clkEn single cycle", int'(ctrClkEn[0]), 0);
    clkPin = '0; gatePin = '0;

    // R12 gate write timing, clock register untouched
    gatePin[0] = 1'b1;
    settle();
    @(negedge clk); gateSelWr = 1'b1; wrData = mk(0, 0, 8); enhanced = 1'b1;
    #1 check(ctrGateLvl[0] == 1'b1, "R12", "gate before edge", int'(ctrGateLvl[0]), 1);
    @(negedge clk); gateSelWr = 1'b0; mGate[0] = 8;
    check(ctrGateLvl[0] == 1'b0, "R12", "gate after edge", int'(ctrGateLvl[0]), 0);
    clkPin[0] = 1'b1;
    repeat (2) @(negedge clk);
    check(ctrClkEn[0] == 1'b1, "R12", "clock setting kept", int'(ctrClkEn[0]), 1);
    clkPin = '0; gatePin = '0;
    settle();

    // R2 addressing: chip 1 channel 2 -> index 5
    writeSel(0, 1, mk(1, 2, 7));
    check(ctrGateLvl == 6'b100000, "R2", "chip1 chan2 index", int'(ctrGateLvl), 32);
    // R3 channel field 3 ignored
    writeSel(1, 1, mk(0, 3, 7));
    writeSel(1, 1, mk(1, 3, 7));
    check(ctrGateLvl == 6'b100000, "R3", "chan3 ignored", int'(ctrGateLvl), 32);

    // R4 standard range
    enhanced = 1'b0;
    writeSel(0, 1, mk(0, 1, 7));
    check(ctrGateLvl == 6'b100010, "R4", "code7 accepted", int'(ctrGateLvl), 34);
    writeSel(0, 1, mk(1, 2, 8));
    check(ctrGateLvl == 6'b100010, "R4", "code8 rejected", int'(ctrGateLvl), 34);
    // R5 enhanced range
    enhanced = 1'b1;
    writeSel(0, 1, mk(0, 1, 11));
    writeSel(0, 1, mk(0, 1, 31));
    check(ctrGateLvl == 6'b100010, "R5", "reserved rejected", int'(ctrGateLvl), 34);
    writeSel(0, 1, mk(1, 2, 8));
    check(ctrGateLvl == 6'b000010, "R5", "code8 accepted", int'(ctrGateLvl), 2);

    // R8 preceding channel with wrap
    for (int c = 0; c < 6; c++) writeSel(0, 1, mk(c / 3, c % 3, 5));
    ctrOut = 6'b000001; settle();
    check(ctrGateLvl == 6'b000010, "R8", "ch0 out to ch1", int'(ctrGateLvl), 2);
    ctrOut = 6'b100000; settle();
    check(ctrGateLvl == 6'b000001, "R8", "ch5 out wraps to ch0", int'(ctrGateLvl), 1);
    ctrOut = 6'b000100; settle();
    check(ctrGateLvl == 6'b001000, "R8", "ch2 out to ch3", int'(ctrGateLvl), 8);
    ctrOut = '0;

    // R9 group clock per chip
    for (int c = 0; c < 6; c++) writeSel(0, 1, mk(c / 3, c % 3, 6));
    grpClkPin = 2'b10; settle();
    check(ctrGateLvl == 6'b111000, "R9", "group pin chip1", int'(ctrGateLvl), 56);
    grpClkPin = 2'b01; settle();
    check(ctrGateLvl == 6'b000111, "R9", "group pin chip0", int'(ctrGateLvl), 7);
    grpClkPin = '0;

    // R10 constant sources give no clock enable
    writeSel(1, 0, mk(1, 1, 7));
    writeSel(1, 0, mk(1, 0, 8));
    clkPin = 6'b011000;
    settle();
    windowCheck("R10");

    // R11 pattern present
    writeSel(1, 1, mk(0, 1, 9));
    settle();
    @(negedge clk); patPresent = 1'b1;
    #1 check(ctrGateLvl[1] == 1'b1, "R11", "gate same cycle", int'(ctrGateLvl[1]), 1);
    check(ctrClkEn[1] == 1'b1, "R11", "edge same cycle", int'(ctrClkEn[1]), 1);
    @(negedge clk);
    check(ctrClkEn[1] == 1'b0, "R11", "edge single cycle", int'(ctrClkEn[1]), 0);
    check(ctrGateLvl[1] == 1'b1, "R11", "gate held", int'(ctrGateLvl[1]), 1);
    patPresent = 1'b0; clkPin = '0;

    // R6 timebase periods
    writeSel(1, 0, mk(0, 0, 10));
    writeSel(1, 0, mk(0, 1, 1));
    writeSel(1, 0, mk(0, 2, 2));
    writeSel(1, 0, mk(1, 0, 3));
    writeSel(1, 0, mk(1, 1, 4));
    measure(0, n); check(n == 2, "R6", "20 MHz period", n, 2);
    measure(1, n); check(n == 4, "R6", "10 MHz period", n, 4);
    measure(2, n); check(n == 40, "R6", "1 MHz period", n, 40);
    measure(3, n); check(n == 4000, "R6", "10 kHz period", n, 4000);
    measure(4, n); check(n == 40000, "R6", "1 kHz period", n, 40000);

    // R2 R4 R5 random writes checked by windows
    for (int r = 0; r < 25; r++) begin
      enhanced = 1'($urandom % 2);
      for (int w = 0; w < 4; w++) begin
        bit tc, tg;
        b = 8'($urandom);
        if ($urandom % 2 == 0) b[7:6] = 2'b00;
        tc = 1'($urandom % 2);
        tg = 1'($urandom % 2);
        if (!tc && !tg) tg = 1'b1;
        writeSel(tc, tg, b);
      end
      gatePin    = 6'($urandom);
      clkPin     = 6'($urandom);
      ctrOut     = 6'($urandom);
      grpClkPin  = 2'($urandom);
      patPresent = 1'($urandom);
      settle();
      windowCheck("R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule